// File: doc/BRIEF.md
# Decoded Parallel I/O Bus Interface

This block sits between a processor-style bus and eight parallel port endpoints: four read-only sources and four write-only output registers. The processor issues a 16-bit address, independent read and write strobes, an I/O-versus-memory qualifier and an 8-bit write data word. On a read, the block returns the selected source byte together with an output-enable that models a three-state driver. On a write, it loads one output register with the data word. Each output register can be cleared on its own.

A build-time parameter selects the addressing scheme. In the memory-mapped scheme (`MODE`=0), every address bit is compared against a fixed port base inside the top I/O window (0xFC00 to 0xFFFF). No address from 0x0000 to 0xFBFF ever reaches a port. In the separate-I/O scheme (`MODE`=1), the qualifier `io_m` must be high, and only the low 8 address bits are compared against a short port base. The two least significant address bits pick one of the four ports in both schemes.

Writes are sequenced by a three-state machine of type `wr_state_e`:

- `WS_IDLE`
  - goes to `WS_ABORT` on read and write together;
  - goes to `WS_STROBE` on write alone.
- `WS_STROBE`
  - records address and data every cycle while the write strobe is held;
  - goes to `WS_ABORT` if read joins the write;
  - goes to `WS_IDLE` when write drops. This transition commits the write.
- `WS_ABORT`
  - returns to `WS_IDLE` only once both strobes are low;
  - commits nothing.

Top module: `pio_bus_decoder`

## Requirements
- R1: With `MODE`=0, only addresses 0xFC00 to 0xFC03 select a port. Every address below 0xFC00, and every other address in 0xFC04 to 0xFFFF, selects none. `io_m` is ignored.
- R2: With `MODE`=1, a port is selected only when `io_m` is 1 and `addr[7:2]` equals 0x40>>2 (ports at low byte 0x40 to 0x43). `addr[15:8]` is ignored. With `io_m` at 0, nothing is selected.
- R3: `addr[1:0]` = k selects port k: source byte k on reads and output register k on writes.
- R4: `rdata_oe` is 1 exactly when a port is selected, `rd` is 1 and `wr` is 0. In that case `rdata` equals source byte k, taken from `src_data[8k+7:8k]`. Otherwise `rdata_oe` is 0 and `rdata` is 0.
- R5: A write loads the data and address present in the last cycle that `wr` was high. The new value appears on `latch_q` after the clock edge at which `wr` is first sampled low. It does not appear earlier.
- R6: A write whose address does not select a port leaves all four output registers unchanged.
- R7: While `rd` and `wr` are both 1, `rdata_oe` is 0. A write strobe that overlaps a read at any point commits nothing. After both strobes drop, the next write works normally.
- R8: A high `clr[k]` zeroes output register k at the next clock edge, even if a write to k commits at that same edge. Other registers keep their values.
- R9: After reset all output registers read 0 and the write sequencer is idle.
- R10: `latch_q[8k+7:8k]` carries the current value of output register k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus address |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| io_m | input | 1 | 1 = I/O access, 0 = memory access (separate-I/O scheme only) |
| wdata | input | 8 | Write data |
| clr | input | 4 | Per-register synchronous clear |
| src_data | input | 32 | Four source bytes, byte k at [8k+7:8k] |
| rdata | output | 8 | Read data, 0 when not driven |
| rdata_oe | output | 1 | Stand-in for a three-state drive enable |
| latch_q | output | 32 | Four output register values, byte k at [8k+7:8k] |

## Verification
The bound checker watches a set of properties on every cycle:

- the drive enable is never high without a lone read strobe;
- released data reads zero;
- memory-range addresses in the memory-mapped build, and memory-qualified accesses in the separate-I/O build, never drive the bus;
- an output register changes only after a write strobe or a clear;
- a clear always leaves zero.

Some behaviours depend on a history of strobes that a single-cycle property cannot tie to the right value. These are shown only by the bench scenarios:

- that exactly the last-held data word lands in the right register;
- that an overlapped write is dropped;
- that clear beats a coincident write;
- that the upper address byte is ignored in the separate-I/O scheme.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int MODE_MEMMAP = 0;
    localparam int MODE_SEPIO  = 1;

    typedef enum logic [1:0] {
        WS_IDLE   = 2'd0,
        WS_STROBE = 2'd1,
        WS_ABORT  = 2'd2
    } wr_state_e;

endpackage

// File: rtl/pio_addr_dec.sv
module pio_addr_dec #(
    parameter int                MODE     = 0,
    parameter int                ADDR_W   = 16,
    parameter int                NPORT    = 4,
    parameter int                RED_W    = 8,
    parameter logic [ADDR_W-1:0] IO_BASE  = 16'hFC00,
    parameter logic [RED_W-1:0]  SEP_BASE = 8'h40,
    localparam int               SEL_W    = $clog2(NPORT)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_m,
    output logic              hit,
    output logic [SEL_W-1:0]  idx
);
    import pio_pkg::*;

    logic mm_hit;
    logic sep_hit;

    // full compare of every bit above the port select field
    assign mm_hit  = (addr[ADDR_W-1:SEL_W] == IO_BASE[ADDR_W-1:SEL_W]);
    // reduced compare, qualified by the I/O line
    assign sep_hit = io_m && (addr[RED_W-1:SEL_W] == SEP_BASE[RED_W-1:SEL_W]);

    assign hit = (MODE == MODE_SEPIO) ? sep_hit : mm_hit;
    assign idx = addr[SEL_W-1:0];

endmodule

// File: rtl/pio_wr_fsm.sv
module pio_wr_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic rd,
    input  logic wr,
    output logic capture,
    output logic commit
);
    import pio_pkg::*;

    wr_state_e st;
    wr_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WS_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            WS_IDLE: begin
                if (wr && rd)   nxt = WS_ABORT;
                else if (wr)    nxt = WS_STROBE;
            end
            WS_STROBE: begin
                if (wr && rd)   nxt = WS_ABORT;
                else if (!wr)   nxt = WS_IDLE;
            end
            WS_ABORT: begin
                if (!wr && !rd) nxt = WS_IDLE;
            end
            default:            nxt = WS_IDLE;
        endcase
    end

    always_comb begin
        capture = (nxt == WS_STROBE);
        commit  = (st == WS_STROBE) && !wr;
    end

endmodule

// File: rtl/pio_out_latch.sv
module pio_out_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (clr)  q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/pio_bus_decoder.sv
module pio_bus_decoder #(
    parameter int                MODE     = 0,
    parameter int                ADDR_W   = 16,
    parameter int                DATA_W   = 8,
    parameter int                NPORT    = 4,
    parameter int                RED_W    = 8,
    parameter logic [ADDR_W-1:0] IO_BASE  = 16'hFC00,
    parameter logic [RED_W-1:0]  SEP_BASE = 8'h40,
    localparam int               SEL_W    = $clog2(NPORT),
    localparam int               BUS_W    = NPORT * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              io_m,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NPORT-1:0]  clr,
    input  logic [BUS_W-1:0]  src_data,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic [BUS_W-1:0]  latch_q
);
    logic             hit;
    logic [SEL_W-1:0] idx;
    logic             capture;
    logic             commit;

    logic              sh_hit;
    logic [SEL_W-1:0]  sh_idx;
    logic [DATA_W-1:0] sh_data;

    pio_addr_dec #(
        .MODE(MODE), .ADDR_W(ADDR_W), .NPORT(NPORT), .RED_W(RED_W),
        .IO_BASE(IO_BASE), .SEP_BASE(SEP_BASE)
    ) dec_i (
        .addr(addr), .io_m(io_m), .hit(hit), .idx(idx)
    );

    pio_wr_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .rd(rd), .wr(wr),
        .capture(capture), .commit(commit)
    );

    // shadow of the write cycle, refreshed while the strobe is held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_hit  <= 1'b0;
            sh_idx  <= '0;
            sh_data <= '0;
        end else if (capture) begin
            sh_hit  <= hit;
            sh_idx  <= idx;
            sh_data <= wdata;
        end
    end

    // read side: drive only for a lone read strobe on a decoded port
    assign rdata_oe = rd && !wr && hit;
    assign rdata    = rdata_oe ? src_data[int'(idx)*DATA_W +: DATA_W] : '0;

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        logic ld;
        assign ld = commit && sh_hit && (sh_idx == SEL_W'(i));
        pio_out_latch #(.DATA_W(DATA_W)) lat_i (
            .clk(clk), .rst_n(rst_n), .clr(clr[i]), .load(ld),
            .d(sh_data), .q(latch_q[i*DATA_W +: DATA_W])
        );
    end

endmodule

// File: rtl/pio_bus_decoder_chk.sv
module pio_bus_decoder_chk #(
    parameter int                MODE    = 0,
    parameter int                ADDR_W  = 16,
    parameter int                DATA_W  = 8,
    parameter int                NPORT   = 4,
    parameter logic [ADDR_W-1:0] IO_BASE = 16'hFC00
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       addr,
    input logic                    rd,
    input logic                    wr,
    input logic                    io_m,
    input logic [NPORT-1:0]        clr,
    input logic [DATA_W-1:0]       rdata,
    input logic                    rdata_oe,
    input logic [NPORT*DATA_W-1:0] latch_q
);
    // R4
    oe_needs_lone_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (rd && !wr));

    // R4
    released_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));

    // R7
    no_drive_on_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && wr) |-> !rdata_oe);

    if (MODE == 0) begin : g_mm
        // R1
        memory_range_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (addr < IO_BASE) |-> !rdata_oe);
    end else begin : g_sep
        // R2
        memory_qualified_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !io_m |-> !rdata_oe);
    end

    for (genvar k = 0; k < NPORT; k++) begin : g_lat
        // R6
        change_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_q[k*DATA_W +: DATA_W] != $past(latch_q[k*DATA_W +: DATA_W]))
            |-> ($past(wr, 2) || $past(clr[k])));
        // R8
        clear_gives_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr[k] |=> (latch_q[k*DATA_W +: DATA_W] == '0));
    end

endmodule

bind pio_bus_decoder pio_bus_decoder_chk #(
    .MODE(MODE), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NPORT(NPORT), .IO_BASE(IO_BASE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .io_m(io_m),
    .clr(clr), .rdata(rdata), .rdata_oe(rdata_oe), .latch_q(latch_q)
);

// File: tb/pio_bus_decoder_tb.sv
`timescale 1ns/1ps
module pio_bus_decoder_tb_top;

    typedef struct packed {
        logic [15:0] a;
        logic        io;
        logic        r;
        logic        w;
        logic        oe0;
        logic [7:0]  d0;
        logic        oe1;
        logic [7:0]  d1;
    } vec_t;

    localparam int NV = 15;
    // columns: addr, io_m, rd, wr, memory-mapped result, separate-I/O result
    localparam vec_t VT [NV] = '{
        '{16'hFC00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h11, 1'b0, 8'h00},
        '{16'hFC01, 1'b0, 1'b1, 1'b0, 1'b1, 8'h22, 1'b0, 8'h00},
        '{16'hFC02, 1'b1, 1'b1, 1'b0, 1'b1, 8'h33, 1'b0, 8'h00},
        '{16'hFC03, 1'b0, 1'b1, 1'b0, 1'b1, 8'h44, 1'b0, 8'h00},
        '{16'hFBFF, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
        '{16'h0000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
        '{16'h0040, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h11},
        '{16'h0041, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
        '{16'hAB42, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h33},
        '{16'h0043, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h44},
        '{16'h0043, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
        '{16'hFC03, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},
        '{16'h0042, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},
        '{16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
        '{16'hFC04, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic        io_m = 1'b0;
    logic [7:0]  wdata = '0;
    logic [3:0]  clr = '0;
    logic [31:0] src_data = 32'h44332211;
    logic [7:0]  rdata0, rdata1;
    logic        oe0, oe1;
    logic [31:0] lq0, lq1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] e0 [4];
    logic [7:0] e1 [4];

    always #4 clk = ~clk;

    pio_bus_decoder #(.MODE(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .io_m(io_m),
        .wdata(wdata), .clr(clr), .src_data(src_data),
        .rdata(rdata0), .rdata_oe(oe0), .latch_q(lq0)
    );

    pio_bus_decoder #(.MODE(1)) dut_sep_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .io_m(io_m),
        .wdata(wdata), .clr(clr), .src_data(src_data),
        .rdata(rdata1), .rdata_oe(oe1), .latch_q(lq1)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_latches(input string tag);
        for (int k = 0; k < 4; k++) begin
            chk(lq0[k*8 +: 8] === e0[k], {tag, " mm"}, {24'h0, lq0[k*8 +: 8]}, {24'h0, e0[k]});
            chk(lq1[k*8 +: 8] === e1[k], {tag, " sep"}, {24'h0, lq1[k*8 +: 8]}, {24'h0, e1[k]});
        end
    endtask

    task automatic wr_op(input logic [15:0] a, input logic iom, input logic [7:0] d);
        @(negedge clk);
        addr = a; io_m = iom; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < 4; k++) begin e0[k] = '0; e1[k] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_latches("R9 reset");

        // table walk: read decode in both schemes
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            addr = VT[v].a; io_m = VT[v].io; rd = VT[v].r; wr = VT[v].w;
            #1;
            chk(oe0 === VT[v].oe0, "R1 R3 R4 R7 oe mm", {31'h0, oe0}, {31'h0, VT[v].oe0});
            chk(rdata0 === VT[v].d0, "R1 R3 R4 data mm", {24'h0, rdata0}, {24'h0, VT[v].d0});
            chk(oe1 === VT[v].oe1, "R2 R3 R4 R7 oe sep", {31'h0, oe1}, {31'h0, VT[v].oe1});
            chk(rdata1 === VT[v].d1, "R2 R3 R4 data sep", {24'h0, rdata1}, {24'h0, VT[v].d1});
        end
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
        @(negedge clk);
        chk_latches("R7 table conflicts wrote nothing");

        // R5 R10 plain writes
        wr_op(16'hFC01, 1'b1, 8'hA5); e0[1] = 8'hA5;
        chk_latches("R5 R10 write mm port1");
        wr_op(16'h0042, 1'b1, 8'h3C); e1[2] = 8'h3C;
        chk_latches("R2 R5 write sep port2");
        wr_op(16'h0042, 1'b0, 8'hC3);
        chk_latches("R2 R6 sep write with io_m low");
        wr_op(16'h0100, 1'b1, 8'h77);
        chk_latches("R1 R6 write to memory address");
        wr_op(16'hFF41, 1'b1, 8'h5E); e1[1] = 8'h5E;
        chk_latches("R2 R6 sep upper byte ignored");

        // R5 last held data wins, not visible before strobe ends
        @(negedge clk);
        addr = 16'hFC03; io_m = 1'b0; wdata = 8'h11; wr = 1'b1;
        @(negedge clk);
        wdata = 8'h77;
        chk_latches("R5 no update during strobe");
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
        e0[3] = 8'h77;
        chk_latches("R5 end-of-strobe data");

        // R7 overlapped write dropped
        @(negedge clk);
        addr = 16'hFC00; wdata = 8'h99; wr = 1'b1;
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
        rd = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk_latches("R7 overlapped write dropped");
        wr_op(16'hFC00, 1'b0, 8'h5A); e0[0] = 8'h5A;
        chk_latches("R7 write after abort");

        // R8 clear single register
        @(negedge clk);
        clr = 4'b0010;
        @(negedge clk);
        clr = 4'b0000; e0[1] = '0; e1[1] = '0;
        chk_latches("R8 clear port1");

        // R8 clear beats coincident commit
        @(negedge clk);
        addr = 16'hFC03; wdata = 8'hEE; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; clr = 4'b1000;
        @(negedge clk);
        clr = 4'b0000; e0[3] = '0; e1[3] = '0;
        chk_latches("R8 clear priority");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule